// File: doc/BRIEF.md
# Scan-Port Debug Transaction Target

This block is the target side of a debug scan port. A host drives the serial pins (mode select, serial in and serial out). The block runs the standard sixteen-state test access port controller on that clock. A 4-bit instruction chooses one of four data registers: a read-only 4-bit progress word, a 4-bit command word, a 32-bit address word and a 32-bit data word. The scan clock is the block clock, and a synchronous active-high reset sets everything to its initial state.

The host first loads an address, write data and a command. When the controller next enters Run-Test/Idle, the block issues one access on a simple request/acknowledge bus. The access can target memory, core registers or auxiliary registers, and it can read or write. A read returns its word into the data register, where the host can scan it out. The progress word shows whether the access is still outstanding, has finished, or has failed. A loaded command stays armed until Test-Logic-Reset, so every further entry into Run-Test/Idle repeats the access with the current address and data. This lets the host stream a block of words by rewriting only the data register.

Top module: `dbg_tap_target`

## Requirements
- R1: The controller follows the standard sixteen-state transition graph on the rising clock edge, and five consecutive clocks with mode-select high bring it to Test-Logic-Reset from any state.
- R2: The instruction register is 4 bits, shifted least significant bit first. Capture-IR loads 4'b0001. Test-Logic-Reset selects instruction 0x8.
- R3: Instruction 0x8 selects the 4-bit progress word, 0x9 the 4-bit command, 0xA the 32-bit address and 0xB the 32-bit data. All are shifted least significant bit first. Any other instruction selects a 1-bit bypass stage that captures 0.
- R4: Capture-DR loads the shift path from the selected holding register. Holding registers change only in Update-DR, so a scan returns the old value and the new value appears only after update, including when the scan is interrupted by Pause-DR.
- R5: An access is launched only in the cycle after the controller enters Run-Test/Idle from another state, and only while a command is armed and no access is outstanding. Scans that move from Update to Select without passing Run-Test/Idle launch nothing. Test-Logic-Reset disarms the command.
- R6: Command 0, 1 and 2 write memory, core and auxiliary space. Command 4, 5 and 6 read the same spaces. The bus space select carries command bits [1:0] (0 memory, 1 core, 2 auxiliary), and write enable is the inverse of command bit 2.
- R7: The request stays high, with address, write data, space and write enable stable, until acknowledge or error. It drops in the cycle after the response.
- R8: Progress bit 0 means stalled, bit 1 failure, bit 2 ready, and bit 3 always reads 0. The word is 4'b0001 while an access is outstanding, 4'b0100 after an acknowledge, 4'b0010 after an error, and 4'b0100 out of reset.
- R9: A read that is acknowledged stores the returned word in the data register. A write, or an access that ends in an error, leaves the data register unchanged.
- R10: Command codes 3 and 7 to 15 make no bus request and set the progress word to 4'b0010 in the launch cycle.
- R11: An armed command is launched again on each later entry into Run-Test/Idle, using the address and data held at that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock, used as the block clock |
| rst | input | 1 | Synchronous active-high reset |
| tms | input | 1 | Controller mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (least significant bit of the active shift path) |
| bus_req | output | 1 | Access request, held until response |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_space | output | 2 | Target space: 0 memory, 1 core, 2 auxiliary |
| bus_addr | output | 32 | Access address |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Access completed |
| bus_err | input | 1 | Access failed |
| bus_rdata | input | 32 | Read data, valid with acknowledge |

## Verification
A holding register takes its new value on the edge that leaves Update-DR. The launch is registered one edge after the controller enters Run-Test/Idle, so the bench expects the request low right after the entry clock and high after the next one. It checks address, space, write enable and data only at that second point. The response is seen on the edge where acknowledge or error is high, and the progress word and read data change on that same edge. The bench reads them back with a full scan afterwards, and it samples serial out before each shift clock, because the first bit is valid once Shift-DR is entered. Each command code is swept under both an acknowledge and an error, and Test-Logic-Reset is reached from the end of every 5-bit mode-select walk.

// File: rtl/dbg_tap_pkg.sv
package dbg_tap_pkg;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  localparam int NIB_W = 4;

  localparam logic [NIB_W-1:0] SEL_PROGRESS = 4'h8;
  localparam logic [NIB_W-1:0] SEL_COMMAND  = 4'h9;
  localparam logic [NIB_W-1:0] SEL_ADDRESS  = 4'hA;
  localparam logic [NIB_W-1:0] SEL_DATAWORD = 4'hB;
  localparam logic [NIB_W-1:0] IR_CAP_PAT   = 4'b0001;

  localparam logic [NIB_W-1:0] PROG_STALL = 4'b0001;
  localparam logic [NIB_W-1:0] PROG_FAIL  = 4'b0010;
  localparam logic [NIB_W-1:0] PROG_READY = 4'b0100;

  // Legal command: bit 3 clear and space field not 3.
  function automatic logic cmd_legal(input logic [NIB_W-1:0] c);
    return (c[3] == 1'b0) && (c[1:0] != 2'b11);
  endfunction

endpackage

// File: rtl/dbg_tap_fsm.sv
module dbg_tap_fsm
  import dbg_tap_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tms,
  output tap_state_e state,
  output logic       idle_entry
);

  tap_state_e nxt;

  always_comb begin
    unique case (state)
      ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_IDLE;
      default:   nxt = ST_RESET;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_RESET;
      idle_entry <= 1'b0;
    end else begin
      state      <= nxt;
      idle_entry <= (nxt == ST_IDLE) && (state != ST_IDLE);
    end
  end

  // Run length of mode-select high, saturating at five.
  localparam logic [2:0] ONES_TO_RESET = 3'd5;
  logic [2:0] ones_run;
  always_ff @(posedge clk) begin
    if (rst)      ones_run <= '0;
    else if (tms) ones_run <= (ones_run == ONES_TO_RESET) ? ones_run : ones_run + 3'd1;
    else          ones_run <= '0;
  end

  assert_five_ones_reset_R1: assert property (@(posedge clk) disable iff (rst)
    (ones_run == ONES_TO_RESET) |-> (state == ST_RESET))
    else $error("controller not in reset after five mode-select ones");

  assert_idle_entry_R5: assert property (@(posedge clk) disable iff (rst)
    idle_entry |-> (state == ST_IDLE))
    else $error("idle entry flagged outside Run-Test/Idle");

endmodule

// File: rtl/dbg_tap_regs.sv
module dbg_tap_regs
  import dbg_tap_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  tap_state_e       state,
  input  logic             tdi,
  input  logic [NIB_W-1:0] progress,
  input  logic             rd_load,
  input  logic [DW-1:0]    rd_value,
  output logic             tdo,
  output logic [NIB_W-1:0] cmd_q,
  output logic [AW-1:0]    addr_q,
  output logic [DW-1:0]    data_q,
  output logic             cmd_upd
);

  localparam int SRW = (AW > DW) ? AW : DW;
  localparam int LW  = $clog2(SRW);

  logic [NIB_W-1:0] ir_sr, ir_q;
  logic [SRW-1:0]   dr_sr, dr_cap, dr_next;
  logic [LW-1:0]    dr_top;

  // Instruction path
  always_ff @(posedge clk) begin
    if (rst || state == ST_RESET) begin
      ir_sr <= '0;
      ir_q  <= SEL_PROGRESS;
    end else begin
      case (state)
        ST_CAP_IR: ir_sr <= IR_CAP_PAT;
        ST_SH_IR:  ir_sr <= {tdi, ir_sr[NIB_W-1:1]};
        ST_UPD_IR: ir_q  <= ir_sr;
        default: ;
      endcase
    end
  end

  // Data path selection: capture value and shift length
  always_comb begin
    case (ir_q)
      SEL_PROGRESS: begin dr_cap = SRW'(progress); dr_top = LW'(NIB_W - 1); end
      SEL_COMMAND:  begin dr_cap = SRW'(cmd_q);    dr_top = LW'(NIB_W - 1); end
      SEL_ADDRESS:  begin dr_cap = SRW'(addr_q);   dr_top = LW'(AW - 1);    end
      SEL_DATAWORD: begin dr_cap = SRW'(data_q);   dr_top = LW'(DW - 1);    end
      default:      begin dr_cap = '0;             dr_top = '0;             end
    endcase
  end

  always_comb begin
    dr_next         = dr_sr >> 1;
    dr_next[dr_top] = tdi;
  end

  assign cmd_upd = (state == ST_UPD_DR) && (ir_q == SEL_COMMAND);

  always_ff @(posedge clk) begin
    if (rst) begin
      dr_sr  <= '0;
      cmd_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      case (state)
        ST_CAP_DR: dr_sr <= dr_cap;
        ST_SH_DR:  dr_sr <= dr_next;
        ST_UPD_DR: begin
          case (ir_q)
            SEL_COMMAND:  cmd_q  <= dr_sr[NIB_W-1:0];
            SEL_ADDRESS:  addr_q <= dr_sr[AW-1:0];
            SEL_DATAWORD: data_q <= dr_sr[DW-1:0];
            default: ;
          endcase
        end
        default: ;
      endcase
      if (rd_load) data_q <= rd_value;
    end
  end

  assign tdo = (state == ST_SH_IR) ? ir_sr[0] : dr_sr[0];

  assert_addr_only_on_update_R4: assert property (@(posedge clk) disable iff (rst)
    (state != ST_UPD_DR) |=> $stable(addr_q))
    else $error("address holding changed outside Update-DR");

  assert_cmd_only_on_update_R4: assert property (@(posedge clk) disable iff (rst)
    (state != ST_UPD_DR) |=> $stable(cmd_q))
    else $error("command holding changed outside Update-DR");

  assert_ir_reset_select_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RESET) |=> (ir_q == SEL_PROGRESS))
    else $error("instruction not reset to progress select");

endmodule

// File: rtl/dbg_xact_engine.sv
module dbg_xact_engine
  import dbg_tap_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_reset,
  input  logic             idle_entry,
  input  logic             cmd_upd,
  input  logic [NIB_W-1:0] cmd,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    data,
  input  logic             bus_ack,
  input  logic             bus_err,
  input  logic [DW-1:0]    bus_rdata,
  output logic             bus_req,
  output logic             bus_we,
  output logic [1:0]       bus_space,
  output logic [AW-1:0]    bus_addr,
  output logic [DW-1:0]    bus_wdata,
  output logic [NIB_W-1:0] progress,
  output logic             rd_load,
  output logic [DW-1:0]    rd_value
);

  logic armed, launch, legal, resp;

  assign legal  = cmd_legal(cmd);
  assign launch = idle_entry && armed && !bus_req;
  assign resp   = bus_req && (bus_ack || bus_err);

  assign rd_load  = bus_req && bus_ack && !bus_err && !bus_we;
  assign rd_value = bus_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed     <= 1'b0;
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_space <= '0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      progress  <= PROG_READY;
    end else begin
      if (in_reset)     armed <= 1'b0;
      else if (cmd_upd) armed <= 1'b1;

      if (launch) begin
        if (legal) begin
          bus_req   <= 1'b1;
          bus_we    <= ~cmd[2];
          bus_space <= cmd[1:0];
          bus_addr  <= addr;
          bus_wdata <= data;
          progress  <= PROG_STALL;
        end else begin
          progress  <= PROG_FAIL;
        end
      end else if (resp) begin
        bus_req  <= 1'b0;
        progress <= bus_err ? PROG_FAIL : PROG_READY;
      end
    end
  end

  assert_launch_from_idle_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req) |-> $past(idle_entry))
    else $error("request raised without entry into Run-Test/Idle");

  assert_req_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack && !bus_err) |=>
      (bus_req && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_we) && $stable(bus_space)))
    else $error("request or its fields moved before response");

  assert_req_drop_R7: assert property (@(posedge clk) disable iff (rst)
    resp |=> !bus_req)
    else $error("request not dropped after response");

  assert_stall_while_busy_R8: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> (progress == PROG_STALL))
    else $error("progress not stalled during access");

  assert_progress_shape_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(progress) && !progress[3])
    else $error("progress word malformed");

  assert_reserved_no_bus_R10: assert property (@(posedge clk) disable iff (rst)
    (launch && !legal) |=> (!bus_req && progress == PROG_FAIL))
    else $error("reserved command reached the bus");

  assert_space_legal_R6: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> (bus_space != 2'b11))
    else $error("illegal space on bus");

endmodule

// File: rtl/dbg_tap_target.sv
module dbg_tap_target
  import dbg_tap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  output logic              bus_req,
  output logic              bus_we,
  output logic [1:0]        bus_space,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic              bus_err,
  input  logic [DATA_W-1:0] bus_rdata
);

  tap_state_e       state;
  logic             idle_entry, cmd_upd, rd_load;
  logic [NIB_W-1:0] cmd_q, progress;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q, rd_value;

  dbg_tap_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .tms        (tms),
    .state      (state),
    .idle_entry (idle_entry)
  );

  dbg_tap_regs #(.AW(ADDR_W), .DW(DATA_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .state    (state),
    .tdi      (tdi),
    .progress (progress),
    .rd_load  (rd_load),
    .rd_value (rd_value),
    .tdo      (tdo),
    .cmd_q    (cmd_q),
    .addr_q   (addr_q),
    .data_q   (data_q),
    .cmd_upd  (cmd_upd)
  );

  dbg_xact_engine #(.AW(ADDR_W), .DW(DATA_W)) u_eng (
    .clk        (clk),
    .rst        (rst),
    .in_reset   (state == ST_RESET),
    .idle_entry (idle_entry),
    .cmd_upd    (cmd_upd),
    .cmd        (cmd_q),
    .addr       (addr_q),
    .data       (data_q),
    .bus_ack    (bus_ack),
    .bus_err    (bus_err),
    .bus_rdata  (bus_rdata),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_space  (bus_space),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .progress   (progress),
    .rd_load    (rd_load),
    .rd_value   (rd_value)
  );

endmodule

// File: tb/tb_dbg_tap_target.sv
module tb_dbg_tap_target;

  logic        clk = 1'b0;
  logic        rst, tms, tdi, tdo;
  logic        bus_req, bus_we, bus_ack, bus_err;
  logic [1:0]  bus_space;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;

  int tests = 0;
  int fails = 0;
  logic [3:0] exp_prog;

  always #2 clk = ~clk;

  dbg_tap_target dut (
    .clk(clk), .rst(rst), .tms(tms), .tdi(tdi), .tdo(tdo),
    .bus_req(bus_req), .bus_we(bus_we), .bus_space(bus_space),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Inputs change at the falling edge; design acts on the rising edge.
  task automatic tick(input logic m, input logic d);
    tms = m;
    tdi = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  // In a Shift state: read serial out, then clock one bit; last bit exits.
  task automatic shift_bits(input int n, input logic [31:0] din, output logic [31:0] dout);
    dout = '0;
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      tick(i == n - 1, din[i]);
    end
  endtask

  // From Run-Test/Idle or an Update state; ends in Update-IR.
  task automatic scan_ir(input logic [3:0] code, output logic [3:0] cap);
    logic [31:0] o;
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    shift_bits(4, {28'd0, code}, o);
    cap = o[3:0];
    tick(1, 0);
  endtask

  // From Run-Test/Idle or an Update state; ends in Update-DR.
  task automatic scan_dr(input int n, input logic [31:0] din, output logic [31:0] dout);
    tick(1, 0); tick(0, 0); tick(0, 0);
    shift_bits(n, din, dout);
    tick(1, 0);
  endtask

  task automatic load(input logic [3:0] sel, input int n, input logic [31:0] v);
    logic [3:0] c;
    logic [31:0] o;
    scan_ir(sel, c);
    scan_dr(n, v, o);
  endtask

  task automatic peek(input logic [3:0] sel, input int n, input logic [31:0] keep, output logic [31:0] v);
    logic [3:0] c;
    scan_ir(sel, c);
    scan_dr(n, keep, v);
  endtask

  task automatic main_flow();
    logic [3:0]  cap;
    logic [31:0] v, a, d, rd, exp_d, o1, o2;
    rst = 1; tms = 1; tdi = 0; bus_ack = 0; bus_err = 0; bus_rdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;

    // Reset state
    chk("R7 request low after reset", {31'd0, bus_req}, 32'd0);
    tick(0, 0);
    scan_dr(4, 0, v);
    chk("R8 progress reset value via default select (R2)", v, 32'h4);
    exp_prog = 4'h4;
    scan_ir(4'hA, cap);
    chk("R2 instruction capture pattern", {28'd0, cap}, 32'h1);
    scan_dr(32, 32'h0, v);
    chk("R3 address reset value", v, 32'h0);

    // R4: interrupted scan returns old value, update applies new
    load(4'hA, 32, 32'h1357_9BDF);
    tick(1, 0); tick(0, 0); tick(0, 0);
    shift_bits(16, 32'h0000_C0DE, o1);
    tick(0, 0); tick(0, 0); tick(1, 0); tick(0, 0);
    shift_bits(16, 32'h0000_FACE, o2);
    tick(1, 0);
    chk("R4 scan returns prior address", {o2[15:0], o1[15:0]}, 32'h1357_9BDF);
    peek(4'hA, 32, 32'hFACE_C0DE, v);
    chk("R4 address after paused scan update", v, 32'hFACE_C0DE);

    // R3: bypass stage delays by one and captures 0
    scan_ir(4'hF, cap);
    tick(1, 0); tick(0, 0); tick(0, 0);
    shift_bits(8, 32'hB6, v);
    tick(1, 0);
    chk("R3 bypass one-stage delay", v, {23'd0, 8'hB6, 1'b0} & 32'hFF);

    // Sweep every command code under both responses
    for (int c = 0; c < 16; c++) begin
      for (int o = 0; o < 2; o++) begin
        logic [3:0] cc;
        logic legal;
        cc = c[3:0];
        legal = (cc[3] == 1'b0) && (cc[1:0] != 2'b11);
        a  = 32'h4000_0000 | (c << 8) | (o << 4);
        d  = 32'hA5A5_0000 ^ (c * 32'h0101_0101) ^ o;
        rd = ~d ^ 32'h0000_1234;
        load(4'hA, 32, a);
        load(4'hB, 32, d);
        load(4'h9, 4, {28'd0, cc});
        tick(0, 0);
        chk("R5 no request on entry edge", {31'd0, bus_req}, 32'd0);
        tick(0, 0);
        if (legal) begin
          chk("R7 request raised", {31'd0, bus_req}, 32'd1);
          chk("R6 write enable from command bit 2", {31'd0, bus_we}, {31'd0, ~cc[2]});
          chk("R6 space from command bits", {30'd0, bus_space}, {30'd0, cc[1:0]});
          chk("R6 address presented", bus_addr, a);
          if (!cc[2]) chk("R6 write data presented", bus_wdata, d);
          peek(4'h8, 4, 32'h0, v);
          chk("R8 stalled while outstanding", v, 32'h1);
          tick(0, 0); tick(0, 0);
          chk("R7 request held, re-entry ignored (R5)", {31'd0, bus_req}, 32'd1);
          chk("R7 address stable", bus_addr, a);
          bus_rdata = rd;
          if (o == 0) bus_ack = 1; else bus_err = 1;
          tick(0, 0);
          bus_ack = 0; bus_err = 0; bus_rdata = '0;
          chk("R7 request dropped after response", {31'd0, bus_req}, 32'd0);
          exp_prog = (o == 0) ? 4'h4 : 4'h2;
          exp_d = (o == 0 && cc[2]) ? rd : d;
        end else begin
          chk("R10 reserved code makes no request", {31'd0, bus_req}, 32'd0);
          exp_prog = 4'h2;
          exp_d = d;
        end
        peek(4'h8, 4, 32'h0, v);
        chk("R8 progress after completion (R10)", v, {28'd0, exp_prog});
        peek(4'hB, 32, exp_d, v);
        chk("R9 data register after access", v, exp_d);
      end
    end

    // R5 and R11: no launch without idle; armed command relaunches
    load(4'hA, 32, 32'h0000_8000);
    load(4'hB, 32, 32'h1111_2222);
    load(4'h9, 4, 32'h0);
    chk("R5 no request after command update alone", {31'd0, bus_req}, 32'd0);
    load(4'hB, 32, 32'h3333_4444);
    chk("R5 no request after further scans", {31'd0, bus_req}, 32'd0);
    for (int k = 0; k < 2; k++) begin
      tick(0, 0); tick(0, 0);
      chk("R11 relaunch raises request", {31'd0, bus_req}, 32'd1);
      chk("R11 relaunch uses current data", bus_wdata, (k == 0) ? 32'h3333_4444 : 32'h5555_6666);
      chk("R11 relaunch keeps address", bus_addr, 32'h0000_8000);
      bus_ack = 1;
      tick(0, 0);
      bus_ack = 0;
      if (k == 0) load(4'hB, 32, 32'h5555_6666);
    end
    exp_prog = 4'h4;

    // R1/R5: reset disarms a loaded reserved command
    load(4'h9, 4, 32'h3);
    repeat (5) tick(1, 0);
    tick(0, 0); tick(0, 0);
    chk("R5 reset disarms command", {31'd0, bus_req}, 32'd0);
    tick(1, 0); tick(0, 0); tick(0, 0);
    shift_bits(4, 32'h0, v);
    tick(1, 0);
    chk("R1 progress untouched after reset entry", v, {28'd0, exp_prog});

    // R1: five ones reach reset after every 5-bit walk
    for (int k = 0; k < 32; k++) begin
      scan_ir(4'hA, cap);
      for (int j = 0; j < 5; j++) tick(k[j], 0);
      repeat (5) tick(1, 0);
      tick(0, 0);
      tick(1, 0); tick(0, 0); tick(0, 0);
      shift_bits(4, 32'h0, v);
      tick(1, 0);
      chk($sformatf("R1 reset reached after walk %0d", k), v, {28'd0, exp_prog});
    end
  endtask

  initial begin
    fork
      main_flow();
      begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule